// File: doc/BRIEF.md
# Posted Store Buffer with Drain Command

This block sits between a processor store port and an external memory write port. When buffering is on, it takes word stores in one cycle and holds up to a parameterised number of them, eight by default. Each held store keeps its address. The block then retires the stores to memory in arrival order, so the processor does not wait on slow memory. When buffering is off, each store goes straight to the memory port, and the processor waits until memory takes it.

Software controls the block through two small registers. A configuration register holds the buffering enable. A control register carries a drain command. The drain command is accepted only when two command bits are written together. It then stays visible until every buffered store has been accepted by memory. Software polls it to learn that an earlier store, for example to a peripheral, has landed.

Both data paths use valid/ready. On the store port, the processor raises `st_valid` and holds address and data stable until `st_ready` is seen high at a clock edge. On the memory port, the block holds `mw_valid`, `mw_addr` and `mw_data` stable until `mw_ready` is high at an edge. Memory may hold `mw_ready` low for any number of cycles. The processor must not change the enable while a pass-through store is still waiting.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset, buffering is off, the buffer is empty, `mw_valid` is low with no store pending, and both registers read as zero.
- R2: With buffering on and the buffer not full, a store is accepted in the cycle it is presented. It appears on the memory port from the following cycle.
- R3: The buffer holds at most DEPTH (default 8) stores. With DEPTH stores held, `st_ready` stays low.
- R4: Buffered stores leave on the memory port in first-in, first-out order, one per accepted handshake, each with its own address and data.
- R5: With buffering off and the buffer empty, a presented store drives the memory port in the same cycle, and `st_ready` follows `mw_ready`.
- R6: Writing the control register at byte offset 0x4 with bit 0 (command qualifier) and bit 1 (drain) both set starts a drain. Both bits read back as 1 until every held store has been accepted by memory, then the hardware clears both to 0.
- R7: A control-register write with only one of bits 0 and 1 set has no effect: the control register reads 0 and stores are still accepted.
- R8: While a drain is in progress, `st_ready` is low.
- R9: If buffering is turned off while stores are held, the held stores are retired first, with new stores stalled. Pass-through starts only once the buffer is empty.
- R10: While `mw_valid` is high and `mw_ready` is low, the memory port keeps `mw_valid`, `mw_addr` and `mw_data` unchanged into the next cycle.
- R11: The configuration register sits at byte offset 0x0, with the buffering enable in bit 0, and reads back what was written. Register writes take effect at the clock edge where `reg_wr` is high. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address (0x0 configuration, 0x4 control) |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Register read data for reg_addr |
| st_valid | input | 1 | Processor store valid |
| st_ready | output | 1 | Processor store accepted at this edge |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory accepts the write at this edge |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |

## Verification
The assertions check four things on every cycle. The memory port holds steady under back-pressure. The fill level never passes the depth. The store port stays stalled when the buffer is full, while a drain is pending, and while held entries retire after buffering is switched off. A pending drain always ends one cycle after the buffer empties. Only the bench scenarios can show the rest: that the retired sequence matches the stored sequence entry by entry, that the drain bits read back set and then clear after the last accepted write, that half-formed drain commands are ignored, and that pass-through resumes after retirement with the new store last in order.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // register byte offsets
  localparam logic [2:0] OFS_CFG = 3'h0;
  localparam logic [2:0] OFS_CTL = 3'h4;
  // bit positions
  localparam int CFG_EN_BIT    = 0;
  localparam int CTL_CMD_BIT   = 0;
  localparam int CTL_DRAIN_BIT = 1;
  localparam int REG_DW        = 2;

  typedef enum logic [1:0] {
    PM_PASS   = 2'd0,
    PM_BUFFER = 2'd1,
    PM_RETIRE = 2'd2
  } port_mode_e;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = AW + DW;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [EW-1:0] store_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store_q[wr_ptr] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_addr = store_q[rd_ptr][EW-1:DW];
  assign head_data = store_q[rd_ptr][DW-1:0];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign level     = cnt_q;
endmodule

// File: rtl/pwb_regs.sv
module pwb_regs
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              drain_done,
  output logic              cfg_en,
  output logic              drain_busy
);
  logic hit_cfg, hit_ctl, drain_req;

  assign hit_cfg   = (reg_addr == OFS_CFG);
  assign hit_ctl   = (reg_addr == OFS_CTL);
  assign drain_req = reg_wr && hit_ctl && reg_wdata[CTL_CMD_BIT] && reg_wdata[CTL_DRAIN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      drain_busy <= 1'b0;
    end else begin
      if (reg_wr && hit_cfg) cfg_en <= reg_wdata[CFG_EN_BIT];
      if (drain_done)        drain_busy <= 1'b0;
      else if (drain_req)    drain_busy <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_cfg) begin
      reg_rdata[CFG_EN_BIT] = cfg_en;
    end else if (hit_ctl) begin
      reg_rdata[CTL_CMD_BIT]   = drain_busy;
      reg_rdata[CTL_DRAIN_BIT] = drain_busy;
    end
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic cfg_en,
  input  logic drain_busy,
  input  logic fifo_empty,
  input  logic fifo_full,
  input  logic st_valid,
  input  logic mw_ready,
  output logic st_ready,
  output logic push,
  output logic pop,
  output logic sel_fifo,
  output logic mw_valid,
  output logic drain_done
);
  port_mode_e mode;

  always_comb begin
    if (cfg_en)           mode = PM_BUFFER;
    else if (!fifo_empty) mode = PM_RETIRE;
    else                  mode = PM_PASS;
  end

  always_comb begin
    case (mode)
      PM_BUFFER: st_ready = !drain_busy && !fifo_full;
      PM_PASS:   st_ready = !drain_busy && mw_ready;
      default:   st_ready = 1'b0;
    endcase
  end

  assign sel_fifo   = !fifo_empty;
  assign push       = (mode == PM_BUFFER) && st_valid && st_ready;
  assign pop        = !fifo_empty && mw_ready;
  assign mw_valid   = !fifo_empty || ((mode == PM_PASS) && st_valid && !drain_busy);
  assign drain_done = drain_busy && fifo_empty;
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
  import pwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [AW-1:0]     st_addr,
  input  logic [DW-1:0]     st_data,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [AW-1:0]     mw_addr,
  output logic [DW-1:0]     mw_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          cfg_en, drain_busy, drain_done;
  logic          fifo_empty, fifo_full, push, pop, sel_fifo;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [CW-1:0] fifo_level;

  pwb_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .drain_done (drain_done),
    .cfg_en     (cfg_en),
    .drain_busy (drain_busy)
  );

  pwb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .level     (fifo_level)
  );

  pwb_ctrl u_ctrl (
    .cfg_en     (cfg_en),
    .drain_busy (drain_busy),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .st_valid   (st_valid),
    .mw_ready   (mw_ready),
    .st_ready   (st_ready),
    .push       (push),
    .pop        (pop),
    .sel_fifo   (sel_fifo),
    .mw_valid   (mw_valid),
    .drain_done (drain_done)
  );

  assign mw_addr = sel_fifo ? head_addr : st_addr;
  assign mw_data = sel_fifo ? head_data : st_data;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       st_ready,
  input logic                       mw_valid,
  input logic                       mw_ready,
  input logic [AW-1:0]              mw_addr,
  input logic [DW-1:0]              mw_data,
  input logic                       cfg_en,
  input logic                       drain_busy,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int CW = $clog2(DEPTH + 1);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    level == CW'(DEPTH) |-> !st_ready); // R3
  AST_DRAIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> !st_ready); // R8
  AST_RETIRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && level != '0 |-> !st_ready); // R9
  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy && level == '0 |=> !drain_busy); // R6
endmodule

bind posted_wr_buf pwb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_ready   (st_ready),
  .mw_valid   (mw_valid),
  .mw_ready   (mw_ready),
  .mw_addr    (mw_addr),
  .mw_data    (mw_data),
  .cfg_en     (cfg_en),
  .drain_busy (drain_busy),
  .level      (fifo_level)
);

// File: tb/posted_wr_buf_tb.sv
module posted_wr_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_1000_AAAA_0001, 64'h0000_1004_AAAA_0002,
    64'h0000_2000_5555_0003, 64'h0000_0008_1234_5678,
    64'hFFFF_FFFC_DEAD_BEEF, 64'h0000_1000_0000_0000,
    64'h8000_0000_FFFF_FFFF, 64'h0000_3010_CAFE_F00D
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [1:0]    reg_wdata = '0;
  logic [1:0]    reg_rdata;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          mw_valid;
  logic          mw_ready = 1'b0;
  logic [AW-1:0] mw_addr;
  logic [DW-1:0] mw_data;

  int checks = 0;
  int errors = 0;
  int cap_n = 0;
  logic [AW-1:0] cap_a [64];
  logic [DW-1:0] cap_d [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  posted_wr_buf #(.AW(AW), .DW(DW), .DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_valid(st_valid),
    .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  // memory model: record every accepted write
  always @(posedge clk) begin
    if (rst_n && mw_valid && mw_ready && cap_n < 64) begin
      cap_a[cap_n] = mw_addr;
      cap_d[cap_n] = mw_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // present a store, wait for acceptance, report stall cycles
  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waited);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    waited = 0;
    forever begin
      #1;
      if (st_ready || waited > 200) break;
      @(negedge clk);
      waited++;
    end
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] rd;
    int w, base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_read(3'h0, rd); chk("R1 cfg", rd, 0);
    reg_read(3'h4, rd); chk("R1 ctl", rd, 0);
    chk("R1 mw_valid", mw_valid, 0);

    // R11 enable buffering, read back
    reg_write(3'h0, 2'b01);
    reg_read(3'h0, rd); chk("R11 cfg readback", rd, 1);

    // table walk: fill with memory stalled (R2)
    mw_ready = 1'b0;
    base = cap_n;
    for (int i = 0; i < NV; i++) begin
      store(VEC[i][63:32], VEC[i][31:0], w);
      chk("R2 one-cycle accept", w, 0);
    end
    chk("R2 head valid", mw_valid, 1);
    chk("R2 head addr", mw_addr, VEC[0][63:32]);
    // R3 ninth store stalls
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h9999_0000; st_data = 32'h9;
    #1; chk("R3 full stall", st_ready, 0);
    @(negedge clk); st_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1; chk("R10 held addr", mw_addr, VEC[0][63:32]);
    chk("R10 held data", mw_data, VEC[0][31:0]);
    chk("R10 held valid", mw_valid, 1);
    mw_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4 count", cap_n - base, NV);
    for (int i = 0; i < NV; i++) begin
      chk("R4 order addr", cap_a[base+i], VEC[i][63:32]);
      chk("R4 order data", cap_d[base+i], VEC[i][31:0]);
    end
    chk("R4 empty after", mw_valid, 0);

    // R5 pass-through
    reg_write(3'h0, 2'b00);
    mw_ready = 1'b0;
    base = cap_n;
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h4000_0010; st_data = 32'h0BAD_CAFE;
    #1;
    chk("R5 same-cycle valid", mw_valid, 1);
    chk("R5 addr through", mw_addr, 32'h4000_0010);
    chk("R5 stall follows ready", st_ready, 0);
    @(negedge clk); mw_ready = 1'b1;
    #1; chk("R5 ready follows", st_ready, 1);
    @(negedge clk); st_valid = 1'b0;
    chk("R5 one write", cap_n - base, 1);
    chk("R5 data", cap_d[base], 32'h0BAD_CAFE);

    // R6 / R8 drain
    reg_write(3'h0, 2'b01);
    mw_ready = 1'b0;
    base = cap_n;
    for (int i = 0; i < 3; i++) store(VEC[i][63:32], VEC[i][31:0], w);
    reg_write(3'h4, 2'b11);
    reg_read(3'h4, rd); chk("R6 bits set", rd, 2'b11);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h7; st_data = 32'h7;
    #1; chk("R8 drain stall", st_ready, 0);
    @(negedge clk); st_valid = 1'b0;
    reg_read(3'h4, rd); chk("R6 still busy", rd, 2'b11);
    mw_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      reg_read(3'h4, rd);
      if (rd == 2'b00) break;
      if (cap_n - base >= 3 && i > 10) break;
    end
    chk("R6 cleared", rd, 0);
    chk("R6 all landed", cap_n - base, 3);

    // R7 half commands ignored
    reg_write(3'h4, 2'b10);
    reg_read(3'h4, rd); chk("R7 drain only", rd, 0);
    reg_write(3'h4, 2'b01);
    reg_read(3'h4, rd); chk("R7 cmd only", rd, 0);
    store(32'h55, 32'h66, w);
    chk("R7 store accepted", w, 0);
    repeat (3) @(negedge clk);

    // R9 disable with pending entries
    mw_ready = 1'b0;
    base = cap_n;
    store(32'hA0, 32'h1, w);
    store(32'hA4, 32'h2, w);
    reg_write(3'h0, 2'b00);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'hB0; st_data = 32'h3;
    #1;
    chk("R9 stalled", st_ready, 0);
    chk("R9 head first", mw_addr, 32'hA0);
    mw_ready = 1'b1;
    w = 0;
    forever begin
      @(negedge clk); #1;
      if (st_ready || w > 20) break;
      w++;
    end
    @(posedge clk);
    @(negedge clk); st_valid = 1'b0;
    chk("R9 count", cap_n - base, 3);
    chk("R9 order 0", cap_a[base], 32'hA0);
    chk("R9 order 1", cap_a[base+1], 32'hA4);
    chk("R9 pass last", cap_a[base+2], 32'hB0);

    // R1 reset again mid-state
    reg_write(3'h0, 2'b01);
    mw_ready = 1'b0;
    store(32'hC0, 32'h4, w);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 flushed", mw_valid, 0);
    reg_read(3'h0, rd); chk("R1 cfg cleared", rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule